// File: doc/BRIEF.md
# Reversible Latch Sequence Controller

This block orders the control steps of a reversible transmission-gate latch, in both directions. It drives three things: the level on the latch input line, the enable of the pass gate, and a registered model of the storage node behind that gate. Every data bit is carried as a pair, a valid bit and a value bit. This keeps a neutral (undriven, discharged) level apart from a logic 0. A bit is neutral when its valid bit is 0, and its value bit is then always 0.

A latch operation begins by placing a copy of the current stored level on the line. Only then does the gate open. The line then moves to the new data, the storage node follows it, the gate closes, and finally the line is withdrawn to neutral. An unlatch operation runs the reverse. A caller-supplied copy of the stored level is presented, the gate opens, the copy is retracted while the gate is still open (which discharges the storage node to neutral), and the gate closes.

The gate must open only between equal levels. When it opens on a mismatch, a sticky dissipation flag is set. A request made while the controller is busy, or two requests at once, is dropped and sets a sticky protocol flag. The requests use a plain pulse interface. `busy` acts as the inverse of a ready signal, and a request is taken only on a clock edge where `busy` is low. There is no queueing, so a caller that ignores `busy` loses its request.

Top module: `rlatch_seq_ctrl`

## Requirements
- R1: After reset the line is neutral (all valid bits 0), the gate is closed, the storage node is neutral, and busy, proto_err and dissip_err are all 0.
- R2: A latch request accepted at edge e0 makes busy high for exactly six cycles. In steps 0 to 5 the gate is 0,1,1,1,0,0. The line carries the previously stored level in steps 0 and 1, the new data in steps 2 to 4, and neutral in step 5. Busy falls at edge e6.
- R3: During a latch, the level on the line equals the stored level in the cycle in which the gate opens, so a latch never sets dissip_err.
- R4: While the gate is open, the storage node takes the line level one clock later. While the gate is closed, the storage node holds its level.
- R5: An unlatch request accepted at edge e0 makes busy high for exactly four cycles. The gate is 0,1,1,0. The line carries the supplied copy in steps 0 and 1 and neutral in steps 2 and 3. The stored level equals the copy in step 2 and is neutral from step 3 onward.
- R6: Data bits are captured masked. A bit whose din_vld is 0 is taken as neutral, whatever its din_val, so no output value bit is ever 1 while its valid bit is 0.
- R7: A latch or unlatch request while busy is ignored: the running sequence and its final stored level do not change. proto_err is set and stays set until reset.
- R8: latch_req and unlatch_req high together while idle start nothing. busy stays 0, the stored level is unchanged, and proto_err is set.
- R9: If the gate opens while the line and stored levels differ in any valid or value bit, dissip_err is set and stays set until reset. The sequence still runs to its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| latch_req | input | 1 | Pulse: store din into the latch |
| unlatch_req | input | 1 | Pulse: release the latch; din is the copy to present |
| din_vld | input | DW | Valid bits of the data or copy level |
| din_val | input | DW | Value bits of the data or copy level |
| line_vld | output | DW | Valid bits of the level on the latch input line |
| line_val | output | DW | Value bits of the level on the latch input line |
| gate_open | output | 1 | Pass-gate enable |
| store_vld | output | DW | Valid bits of the storage node model |
| store_val | output | DW | Value bits of the storage node model |
| busy | output | 1 | A sequence is running; requests are not taken |
| proto_err | output | 1 | Sticky: a request was dropped |
| dissip_err | output | 1 | Sticky: gate opened between unequal levels |

## Verification
The assertions take requests to be single-cycle pulses sampled at a rising edge. They do not assume that the caller respects busy: dropping a request while busy is a checked behaviour. The one-pass latch check also assumes nothing about din, because the latch copy comes from the storage node itself. The random stimulus always waits for busy to fall before a legal request, and it supplies a correct unlatch copy. Requests during busy, double requests and wrong copies are applied only in directed cases, each followed by a reset that clears the sticky flags.

// File: rtl/rl_pkg.sv
package rl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_L_PRES,
    ST_L_OPEN,
    ST_L_CHG,
    ST_L_FOL,
    ST_L_CLOSE,
    ST_L_RET,
    ST_U_PRES,
    ST_U_OPEN,
    ST_U_RET,
    ST_U_CLOSE
  } step_e;

  typedef enum logic [1:0] {
    SRC_NEUTRAL,
    SRC_COPY,
    SRC_NEW
  } src_e;

endpackage

// File: rtl/rl_seq_fsm.sv
module rl_seq_fsm
  import rl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  latch_req,
  input  logic  unlatch_req,
  output step_e step,
  output logic  busy,
  output logic  gate_cmd,
  output src_e  src,
  output logic  take_latch,
  output logic  take_unlatch,
  output logic  proto_err
);

  step_e step_q, step_d;
  logic  perr_q;
  logic  idle;
  logic  any_req;

  assign idle         = (step_q == ST_IDLE);
  assign any_req      = latch_req | unlatch_req;
  assign take_latch   = idle & latch_req & ~unlatch_req;
  assign take_unlatch = idle & unlatch_req & ~latch_req;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE: begin
        if (take_latch)        step_d = ST_L_PRES;
        else if (take_unlatch) step_d = ST_U_PRES;
      end
      ST_L_PRES:  step_d = ST_L_OPEN;
      ST_L_OPEN:  step_d = ST_L_CHG;
      ST_L_CHG:   step_d = ST_L_FOL;
      ST_L_FOL:   step_d = ST_L_CLOSE;
      ST_L_CLOSE: step_d = ST_L_RET;
      ST_L_RET:   step_d = ST_IDLE;
      ST_U_PRES:  step_d = ST_U_OPEN;
      ST_U_OPEN:  step_d = ST_U_RET;
      ST_U_RET:   step_d = ST_U_CLOSE;
      ST_U_CLOSE: step_d = ST_IDLE;
      default:    step_d = ST_IDLE;
    endcase
  end

  always_comb begin
    gate_cmd = 1'b0;
    src      = SRC_NEUTRAL;
    unique case (step_q)
      ST_L_PRES:  src = SRC_COPY;
      ST_L_OPEN:  begin src = SRC_COPY; gate_cmd = 1'b1; end
      ST_L_CHG:   begin src = SRC_NEW;  gate_cmd = 1'b1; end
      ST_L_FOL:   begin src = SRC_NEW;  gate_cmd = 1'b1; end
      ST_L_CLOSE: src = SRC_NEW;
      ST_U_PRES:  src = SRC_COPY;
      ST_U_OPEN:  begin src = SRC_COPY; gate_cmd = 1'b1; end
      ST_U_RET:   gate_cmd = 1'b1;
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      perr_q <= 1'b0;
    end else begin
      step_q <= step_d;
      if ((!idle && any_req) || (idle && latch_req && unlatch_req))
        perr_q <= 1'b1;
    end
  end

  assign step      = step_q;
  assign busy      = ~idle;
  assign proto_err = perr_q;

  AST_BUSY_REQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && any_req) |=> proto_err) else $error("busy request not flagged"); // R7
  AST_DOUBLE_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && latch_req && unlatch_req) |=> (!busy && proto_err)) else $error("double request started"); // R8
  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err) else $error("proto_err cleared"); // R7

endmodule

// File: rtl/rl_line_drive.sv
module rl_line_drive
  import rl_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_latch,
  input  logic          take_unlatch,
  input  logic [DW-1:0] din_vld,
  input  logic [DW-1:0] din_val,
  input  logic [DW-1:0] store_vld,
  input  logic [DW-1:0] store_val,
  input  src_e          src,
  output logic [DW-1:0] line_vld,
  output logic [DW-1:0] line_val
);

  logic [DW-1:0] copy_vld_q, copy_val_q;
  logic [DW-1:0] new_vld_q,  new_val_q;
  logic [DW-1:0] din_val_m;

  assign din_val_m = din_val & din_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      copy_vld_q <= '0;
      copy_val_q <= '0;
      new_vld_q  <= '0;
      new_val_q  <= '0;
    end else if (take_latch) begin
      copy_vld_q <= store_vld;
      copy_val_q <= store_val;
      new_vld_q  <= din_vld;
      new_val_q  <= din_val_m;
    end else if (take_unlatch) begin
      copy_vld_q <= din_vld;
      copy_val_q <= din_val_m;
    end
  end

  generate
    for (genvar b = 0; b < DW; b++) begin : g_bit
      always_comb begin
        unique case (src)
          SRC_COPY: begin line_vld[b] = copy_vld_q[b]; line_val[b] = copy_val_q[b]; end
          SRC_NEW:  begin line_vld[b] = new_vld_q[b];  line_val[b] = new_val_q[b];  end
          default:  begin line_vld[b] = 1'b0;          line_val[b] = 1'b0;          end
        endcase
      end
    end
  endgenerate

  AST_LINE_NEUTRAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_val & ~line_vld) == '0)) else $error("neutral bit carries value"); // R6

endmodule

// File: rtl/rl_store_node.sv
module rl_store_node #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate,
  input  logic [DW-1:0] line_vld,
  input  logic [DW-1:0] line_val,
  output logic [DW-1:0] store_vld,
  output logic [DW-1:0] store_val
);

  logic [DW-1:0] vld_q, val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      val_q <= '0;
    end else if (gate) begin
      vld_q <= line_vld;
      val_q <= line_val;
    end
  end

  assign store_vld = vld_q;
  assign store_val = val_q;

  AST_STORE_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> ($stable(store_vld) && $stable(store_val))) else $error("store moved while closed"); // R4

endmodule

// File: rtl/rl_gate_monitor.sv
module rl_gate_monitor #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate,
  input  logic [DW-1:0] line_vld,
  input  logic [DW-1:0] line_val,
  input  logic [DW-1:0] store_vld,
  input  logic [DW-1:0] store_val,
  output logic          dissip_err
);

  logic gate_prev_q;
  logic derr_q;
  logic opening;
  logic mismatch;

  assign opening  = gate & ~gate_prev_q;
  assign mismatch = (line_vld != store_vld) || (line_val != store_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_prev_q <= 1'b0;
      derr_q      <= 1'b0;
    end else begin
      gate_prev_q <= gate;
      if (opening && mismatch) derr_q <= 1'b1;
    end
  end

  assign dissip_err = derr_q;

  AST_DERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dissip_err |=> dissip_err) else $error("dissip_err cleared"); // R9

endmodule

// File: rtl/rlatch_seq_ctrl.sv
module rlatch_seq_ctrl
  import rl_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_req,
  input  logic          unlatch_req,
  input  logic [DW-1:0] din_vld,
  input  logic [DW-1:0] din_val,
  output logic [DW-1:0] line_vld,
  output logic [DW-1:0] line_val,
  output logic          gate_open,
  output logic [DW-1:0] store_vld,
  output logic [DW-1:0] store_val,
  output logic          busy,
  output logic          proto_err,
  output logic          dissip_err
);

  step_e step;
  src_e  src;
  logic  take_latch, take_unlatch;

  rl_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .latch_req    (latch_req),
    .unlatch_req  (unlatch_req),
    .step         (step),
    .busy         (busy),
    .gate_cmd     (gate_open),
    .src          (src),
    .take_latch   (take_latch),
    .take_unlatch (take_unlatch),
    .proto_err    (proto_err)
  );

  rl_line_drive #(.DW(DW)) u_drive (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_latch   (take_latch),
    .take_unlatch (take_unlatch),
    .din_vld      (din_vld),
    .din_val      (din_val),
    .store_vld    (store_vld),
    .store_val    (store_val),
    .src          (src),
    .line_vld     (line_vld),
    .line_val     (line_val)
  );

  rl_store_node #(.DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate      (gate_open),
    .line_vld  (line_vld),
    .line_val  (line_val),
    .store_vld (store_vld),
    .store_val (store_val)
  );

  rl_gate_monitor #(.DW(DW)) u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate       (gate_open),
    .line_vld   (line_vld),
    .line_val   (line_val),
    .store_vld  (store_vld),
    .store_val  (store_val),
    .dissip_err (dissip_err)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!gate_open && line_vld == '0)) else $error("idle but driving"); // R2
  AST_LATCH_OPENS_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && step == ST_L_OPEN) |-> (line_vld == store_vld && line_val == store_val))
    else $error("latch opened on mismatch"); // R3
  AST_UNLATCH_ENDS_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_U_CLOSE) |-> (store_vld == '0)) else $error("unlatch left charge"); // R5

endmodule

// File: tb/test_rlatch_seq_ctrl.sv
module test_rlatch_seq_ctrl;

  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          latch_req = 1'b0;
  logic          unlatch_req = 1'b0;
  logic [DW-1:0] din_vld = '0;
  logic [DW-1:0] din_val = '0;
  logic [DW-1:0] line_vld, line_val, store_vld, store_val;
  logic          gate_open, busy, proto_err, dissip_err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [DW-1:0] m_vld = '0;
  logic [DW-1:0] m_val = '0;

  always #2 clk = ~clk;

  rlatch_seq_ctrl #(.DW(DW)) i_rlatch_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .latch_req(latch_req), .unlatch_req(unlatch_req),
    .din_vld(din_vld), .din_val(din_val), .line_vld(line_vld), .line_val(line_val),
    .gate_open(gate_open), .store_vld(store_vld), .store_val(store_val),
    .busy(busy), .proto_err(proto_err), .dissip_err(dissip_err)
  );

  function automatic logic [2*DW-1:0] lv(input logic [DW-1:0] v, input logic [DW-1:0] x);
    return {v, x & v};
  endfunction

  function automatic logic lat_gate(input int k);
    return (k >= 1 && k <= 3);
  endfunction

  function automatic logic unl_gate(input int k);
    return (k == 1 || k == 2);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; latch_req = 1'b0; unlatch_req = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_vld = '0; m_val = '0;
  endtask

  // inj >= 0 pulses unlatch_req during that busy step
  task automatic do_latch(input logic [DW-1:0] v, input logic [DW-1:0] x, input int inj);
    logic [2*DW-1:0] old_l, new_l;
    old_l = {m_vld, m_val};
    new_l = lv(v, x);
    din_vld = v; din_val = x; latch_req = 1'b1;
    @(negedge clk);
    latch_req = 1'b0; din_vld = $urandom; din_val = $urandom;
    for (int k = 0; k < 6; k++) begin
      unlatch_req = (k == inj);
      chk("R2 busy", busy, 1);
      chk("R2 gate", gate_open, lat_gate(k));
      chk("R2 line", {line_vld, line_val}, (k <= 1) ? old_l : (k <= 4) ? new_l : '0);
      chk("R4 store", {store_vld, store_val}, (k <= 2) ? old_l : new_l);
      if (k == 1) chk("R3 match at open", {line_vld, line_val}, {store_vld, store_val});
      @(negedge clk);
    end
    unlatch_req = 1'b0;
    chk("R2 busy end", busy, 0);
    chk("R4 store held", {store_vld, store_val}, new_l);
    chk("R6 masked", store_val & ~store_vld, 0);
    {m_vld, m_val} = new_l;
  endtask

  task automatic do_unlatch(input logic [DW-1:0] v, input logic [DW-1:0] x);
    logic [2*DW-1:0] old_l, cp_l;
    old_l = {m_vld, m_val};
    cp_l  = lv(v, x);
    din_vld = v; din_val = x; unlatch_req = 1'b1;
    @(negedge clk);
    unlatch_req = 1'b0; din_vld = $urandom; din_val = $urandom;
    for (int k = 0; k < 4; k++) begin
      chk("R5 busy", busy, 1);
      chk("R5 gate", gate_open, unl_gate(k));
      chk("R5 line", {line_vld, line_val}, (k <= 1) ? cp_l : '0);
      chk("R5 store", {store_vld, store_val}, (k <= 1) ? old_l : (k == 2) ? cp_l : '0);
      @(negedge clk);
    end
    chk("R5 busy end", busy, 0);
    chk("R5 store neutral", {store_vld, store_val}, 0);
    m_vld = '0; m_val = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20031));
    do_reset();
    chk("R1 busy", busy, 0);
    chk("R1 gate", gate_open, 0);
    chk("R1 line", {line_vld, line_val}, 0);
    chk("R1 store", {store_vld, store_val}, 0);
    chk("R1 perr", proto_err, 0);
    chk("R1 derr", dissip_err, 0);

    // directed: latch all-ones, then R6 masking, then proper unlatch
    do_latch(4'hF, 4'hF, -1);
    do_latch(4'h5, 4'hF, -1);
    chk("R6 store val", store_val, 4'h5);
    do_unlatch(m_vld, m_val);
    do_latch(4'h0, 4'hA, -1);

    // random legal traffic
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(1, 0) == 1) do_latch($urandom, $urandom, -1);
      else                           do_unlatch(m_vld, m_val);
      if ($urandom_range(2, 0) == 0) @(negedge clk);
    end
    chk("R3 no dissipation on legal use", dissip_err, 0);
    chk("R7 no protocol error on legal use", proto_err, 0);

    // R7: request during busy ignored
    do_reset();
    do_latch(4'hC, 4'h8, -1);
    do_latch(4'h3, 4'h2, 2);
    chk("R7 perr set", proto_err, 1);
    chk("R7 store kept", {store_vld, store_val}, {4'h3, 4'h2});
    @(negedge clk); @(negedge clk);
    chk("R7 perr sticky", proto_err, 1);
    chk("R7 still idle", busy, 0);

    // R8: both requests in idle
    do_reset();
    do_latch(4'h9, 4'h1, -1);
    din_vld = 4'hF; din_val = 4'h0;
    latch_req = 1'b1; unlatch_req = 1'b1;
    @(negedge clk);
    latch_req = 1'b0; unlatch_req = 1'b0;
    chk("R8 not busy", busy, 0);
    chk("R8 perr", proto_err, 1);
    @(negedge clk);
    chk("R8 store unchanged", {store_vld, store_val}, {4'h9, 4'h1});

    // R9: unlatch with a wrong copy
    do_reset();
    do_latch(4'hF, 4'h6, -1);
    chk("R9 no err before", dissip_err, 0);
    do_unlatch(4'hF, 4'h7);
    chk("R9 derr set", dissip_err, 1);
    @(negedge clk); @(negedge clk);
    chk("R9 derr sticky", dissip_err, 1);
    chk("R9 perr clean", proto_err, 0);

    // R9: wrong valid pattern (neutral copy of a charged node)
    do_reset();
    do_latch(4'h2, 4'h2, -1);
    do_unlatch(4'h0, 4'h0);
    chk("R9 derr neutral copy", dissip_err, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule